// File: doc/BRIEF.md
# Interleaved Stride DMA Address Generator

This block produces the address stream for a strided (interleaved) transfer between main memory and a 16 KB scratchpad. A start pulse latches a total quadword count, a group size, a skip size, a main-memory byte address and a scratchpad byte address. The block then issues one quadword beat per accepted handshake. Within a group both addresses step by 16 bytes. After each group the main-memory address also jumps over the skip area. The scratchpad address wraps at the end of the 16 KB space.

Each group holds the smaller of the group size and the quadwords still owed. A group size of zero means the whole count forms one group. A warning level marks the first beat of any group that would run past the top of the scratchpad. When the transfer runs toward main memory and stall control names this channel, the final main-memory address is recorded as the stall address, together with the completion pulse. The data path itself lies outside this block: it only provides the addresses and the beat handshake.

Top module: `ilv_stride_agen`

## Requirements
- R1: The quadwords of a transfer are issued in groups. Each group holds min(tqwc_in, remaining), and when tqwc_in is 0 the whole qwc_in forms one group.
- R2: mem_addr starts at madr_in and rises by 16 after every beat. After the last beat of every group, including the final group, it rises by a further sqwc_in*16. The arithmetic wraps modulo 2^AW.
- R3: spad_addr starts at sadr_in and rises by 16 after every beat, wrapping modulo 16384 (mask 0x3FFF).
- R4: beat_valid is 1 exactly while busy is 1. A beat completes on a clock edge where beat_valid and beat_ready are both 1. While beat_ready is 0, mem_addr and spad_addr hold their values.
- R5: done is a single-cycle pulse in the cycle that follows the final beat. In that cycle busy is 0 and qwc_left is 0.
- R6: When dir_to_mem=1 and stall_sel=1 were latched at start, stall_wr pulses together with done and stall_addr takes the final address, the one that includes the trailing skip. Otherwise stall_wr stays 0 and stall_addr keeps its previous value (0 after reset).
- R7: overrun_warn is 1 on the first beat of a group, and only there, when the group size exceeds 1024 - spad_addr[13:4].
- R8: A start pulse while busy is 1 is ignored and has no effect on the running address sequence.
- R9: A start with qwc_in = 0 issues no beat. done pulses in the next cycle, and the stall record of R6 uses madr_in.
- R10: After reset, busy, beat_valid, done, stall_wr, qwc_left and stall_addr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, honoured only when idle |
| dir_to_mem | input | 1 | 1 = scratchpad to main memory |
| stall_sel | input | 1 | Stall control names this channel |
| qwc_in | input | QWC_W | Total quadword count |
| tqwc_in | input | QWC_W | Group size in quadwords (0 = whole count) |
| sqwc_in | input | QWC_W | Skip size in quadwords |
| madr_in | input | AW | Main-memory start byte address |
| sadr_in | input | SAW | Scratchpad start byte address |
| beat_ready | input | 1 | Downstream accepts the beat |
| beat_valid | output | 1 | Beat addresses are valid |
| mem_addr | output | AW | Main-memory byte address of the beat |
| spad_addr | output | SAW | Scratchpad byte address of the beat |
| overrun_warn | output | 1 | Group would run past the scratchpad end |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Completion pulse |
| qwc_left | output | QWC_W | Quadwords still owed |
| stall_wr | output | 1 | Stall address written this cycle |
| stall_addr | output | AW | Recorded stall address |

## Verification
The hardest situation to reach is a group boundary that coincides with handshake back-pressure near the top of the scratchpad. In that case the skip jump, the scratchpad wrap and the overrun warning all act at once. Directed runs therefore place sadr_in a few quadwords below 0x4000 and use group sizes larger than the room left. Random runs then mix small counts, zero and oversized group sizes, and a ready signal that drops about one cycle in four. A start pulse is also injected in the middle of a transfer to show that it is ignored.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
   typedef enum logic {ST_IDLE, ST_RUN} ilv_state_e;
   localparam int QW_SHIFT = 4;
endpackage

// File: rtl/ilv_grp_size.sv
module ilv_grp_size #(
   parameter int QWC_W = 16
) (
   input  logic [QWC_W-1:0] tsz,
   input  logic [QWC_W-1:0] rem,
   output logic [QWC_W-1:0] gsize
);
   always_comb begin
      if (tsz == '0 || tsz > rem) gsize = rem;
      else                        gsize = tsz;
   end
endmodule

// File: rtl/ilv_room_chk.sv
module ilv_room_chk #(
   parameter int QWC_W  = 16,
   parameter int SLOT_W = 10
) (
   input  logic [SLOT_W-1:0] slot,
   input  logic [QWC_W-1:0]  gsize,
   output logic              over
);
   localparam int CW = ((QWC_W > SLOT_W + 1) ? QWC_W : SLOT_W + 1) + 1;
   localparam logic [CW-1:0] NSLOTS = CW'(1) << SLOT_W;
   logic [CW-1:0] room;
   assign room = NSLOTS - CW'(slot);
   assign over = CW'(gsize) > room;
endmodule

// File: rtl/ilv_addr_unit.sv
module ilv_addr_unit #(
   parameter int AW    = 32,
   parameter int SAW   = 14,
   parameter int QWC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [AW-1:0]    madr_ld,
   input  logic [SAW-1:0]   sadr_ld,
   input  logic             step,
   input  logic             grp_end,
   input  logic [QWC_W-1:0] sqwc,
   output logic [AW-1:0]    madr,
   output logic [AW-1:0]    madr_nxt,
   output logic [SAW-1:0]   sadr
);
   import ilv_pkg::*;
   localparam logic [AW-1:0]  M_QW = AW'(1) << QW_SHIFT;
   localparam logic [SAW-1:0] S_QW = SAW'(1) << QW_SHIFT;

   logic [AW-1:0] skip;
   assign skip     = AW'(sqwc) << QW_SHIFT;
   assign madr_nxt = madr + M_QW + (grp_end ? skip : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         madr <= '0;
         sadr <= '0;
      end else if (load) begin
         madr <= madr_ld;
         sadr <= sadr_ld;
      end else if (step) begin
         madr <= madr_nxt;
         sadr <= sadr + S_QW;
      end
   end
endmodule

// File: rtl/ilv_stride_agen.sv
module ilv_stride_agen
   import ilv_pkg::*;
#(
   parameter int AW    = 32,
   parameter int SAW   = 14,
   parameter int QWC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             dir_to_mem,
   input  logic             stall_sel,
   input  logic [QWC_W-1:0] qwc_in,
   input  logic [QWC_W-1:0] tqwc_in,
   input  logic [QWC_W-1:0] sqwc_in,
   input  logic [AW-1:0]    madr_in,
   input  logic [SAW-1:0]   sadr_in,
   input  logic             beat_ready,
   output logic             beat_valid,
   output logic [AW-1:0]    mem_addr,
   output logic [SAW-1:0]   spad_addr,
   output logic             overrun_warn,
   output logic             busy,
   output logic             done,
   output logic [QWC_W-1:0] qwc_left,
   output logic             stall_wr,
   output logic [AW-1:0]    stall_addr
);
   localparam int SLOT_W = SAW - QW_SHIFT;

   generate
      if (SAW < QW_SHIFT + 1) begin : g_bad_saw
         $error("SAW must exceed the quadword shift");
      end
      if (QWC_W < 1 || QWC_W > 30) begin : g_bad_qwc
         $error("QWC_W out of range");
      end
      if (AW < QWC_W + QW_SHIFT + 1) begin : g_bad_aw
         $error("AW too narrow for the skip span");
      end
   endgenerate

   ilv_state_e       state_q;
   logic [QWC_W-1:0] rem_q, grp_q, tsz_q, sqwc_q;
   logic             first_q, rec_q, done_q, stall_wr_q;
   logic [AW-1:0]    stall_addr_q;

   logic             idle, accept, go, hs, grp_end, fin;
   logic [QWC_W-1:0] sz_t, sz_r, gsize;
   logic [AW-1:0]    madr, madr_nxt;
   logic [SAW-1:0]   sadr;
   logic             over;

   assign idle    = (state_q == ST_IDLE);
   assign accept  = start && idle;
   assign go      = accept && (qwc_in != '0);
   assign hs      = !idle && beat_ready;
   assign grp_end = (grp_q == QWC_W'(1));
   assign fin     = hs && (rem_q == QWC_W'(1));
   assign sz_t    = idle ? tqwc_in : tsz_q;
   assign sz_r    = idle ? qwc_in  : rem_q - QWC_W'(1);

   ilv_grp_size #(.QWC_W(QWC_W)) u_size (
      .tsz   (sz_t),
      .rem   (sz_r),
      .gsize (gsize)
   );

   ilv_room_chk #(.QWC_W(QWC_W), .SLOT_W(SLOT_W)) u_room (
      .slot  (sadr[SAW-1:QW_SHIFT]),
      .gsize (grp_q),
      .over  (over)
   );

   ilv_addr_unit #(.AW(AW), .SAW(SAW), .QWC_W(QWC_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (go),
      .madr_ld  (madr_in),
      .sadr_ld  (sadr_in),
      .step     (hs),
      .grp_end  (grp_end),
      .sqwc     (sqwc_q),
      .madr     (madr),
      .madr_nxt (madr_nxt),
      .sadr     (sadr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         rem_q        <= '0;
         grp_q        <= '0;
         tsz_q        <= '0;
         sqwc_q       <= '0;
         first_q      <= 1'b0;
         rec_q        <= 1'b0;
         done_q       <= 1'b0;
         stall_wr_q   <= 1'b0;
         stall_addr_q <= '0;
      end else begin
         done_q     <= 1'b0;
         stall_wr_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  tsz_q  <= tqwc_in;
                  sqwc_q <= sqwc_in;
                  rec_q  <= dir_to_mem && stall_sel;
                  if (qwc_in == '0) begin
                     done_q <= 1'b1;
                     rem_q  <= '0;
                     if (dir_to_mem && stall_sel) begin
                        stall_wr_q   <= 1'b1;
                        stall_addr_q <= madr_in;
                     end
                  end else begin
                     state_q <= ST_RUN;
                     rem_q   <= qwc_in;
                     grp_q   <= gsize;
                     first_q <= 1'b1;
                  end
               end
            end
            default: begin
               if (hs) begin
                  rem_q   <= rem_q - QWC_W'(1);
                  first_q <= 1'b0;
                  if (grp_end) begin
                     grp_q   <= gsize;
                     first_q <= !fin;
                  end else begin
                     grp_q <= grp_q - QWC_W'(1);
                  end
                  if (fin) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                     if (rec_q) begin
                        stall_wr_q   <= 1'b1;
                        stall_addr_q <= madr_nxt;
                     end
                  end
               end
            end
         endcase
      end
   end

   assign busy         = !idle;
   assign beat_valid   = !idle;
   assign mem_addr     = madr;
   assign spad_addr    = sadr;
   assign overrun_warn = !idle && first_q && over;
   assign done         = done_q;
   assign qwc_left     = rem_q;
   assign stall_wr     = stall_wr_q;
   assign stall_addr   = stall_addr_q;
endmodule

// File: rtl/ilv_stride_agen_chk.sv
module ilv_stride_agen_chk #(
   parameter int AW    = 32,
   parameter int SAW   = 14,
   parameter int QWC_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [QWC_W-1:0] qwc_in,
   input logic             beat_ready,
   input logic             beat_valid,
   input logic [AW-1:0]    mem_addr,
   input logic [SAW-1:0]   spad_addr,
   input logic             overrun_warn,
   input logic             busy,
   input logic             done,
   input logic [QWC_W-1:0] qwc_left,
   input logic             stall_wr
);
   AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid && !beat_ready |=> beat_valid && $stable(mem_addr) && $stable(spad_addr)); // R4
   AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid == busy); // R4
   AST_SPAD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid && $past(beat_valid) && $past(beat_ready) |-> spad_addr == $past(spad_addr) + SAW'(16)); // R3
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R5
   AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(beat_valid) && $past(beat_ready)) || ($past(start) && !$past(busy) && $past(qwc_in) == '0)); // R9
   AST_DONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> qwc_left == '0 && !busy); // R5
   AST_STALL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      stall_wr |-> done); // R6
   AST_WARN_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_warn |-> beat_valid); // R7
endmodule

bind ilv_stride_agen ilv_stride_agen_chk #(.AW(AW), .SAW(SAW), .QWC_W(QWC_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .qwc_in       (qwc_in),
   .beat_ready   (beat_ready),
   .beat_valid   (beat_valid),
   .mem_addr     (mem_addr),
   .spad_addr    (spad_addr),
   .overrun_warn (overrun_warn),
   .busy         (busy),
   .done         (done),
   .qwc_left     (qwc_left),
   .stall_wr     (stall_wr)
);

// File: tb/ilv_stride_agen_tb_top.sv
`timescale 1ns/1ps
module ilv_stride_agen_tb_top;
   localparam int AW = 32, SAW = 14, QWC_W = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 0, dir_to_mem = 0, stall_sel = 0, beat_ready = 0;
   logic [QWC_W-1:0] qwc_in = '0, tqwc_in = '0, sqwc_in = '0;
   logic [AW-1:0] madr_in = '0;
   logic [SAW-1:0] sadr_in = '0;
   logic beat_valid, overrun_warn, busy, done, stall_wr;
   logic [AW-1:0] mem_addr, stall_addr;
   logic [SAW-1:0] spad_addr;
   logic [QWC_W-1:0] qwc_left;

   int checks = 0, fails = 0;
   logic [AW-1:0] exp_stall = '0;

   always #4 clk = ~clk;

   ilv_stride_agen #(.AW(AW), .SAW(SAW), .QWC_W(QWC_W)) dut_i (.*);

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int grp_of(int t, int rem);
      return (t == 0 || t > rem) ? rem : t;
   endfunction

   task automatic run_xfer(int q, int t, int s, logic [AW-1:0] m, logic [SAW-1:0] sa,
                           bit d, bit st, bit poke);
      logic [AW-1:0] em = m;
      logic [SAW-1:0] es = sa;
      int rem = q, gl, beats = 0, guard = 0;
      bit first = 1'b1, r, ew;
      @(negedge clk);
      start = 1; qwc_in = QWC_W'(q); tqwc_in = QWC_W'(t); sqwc_in = QWC_W'(s);
      madr_in = m; sadr_in = sa; dir_to_mem = d; stall_sel = st;
      @(negedge clk);
      start = 0; qwc_in = QWC_W'($urandom); madr_in = $urandom; sadr_in = SAW'($urandom);
      gl = grp_of(t, q);
      while (rem > 0 && guard < 5000) begin
         guard++;
         chk(beat_valid === 1'b1, "R4", "valid while busy", beat_valid, 1);
         chk(mem_addr === em, "R2", "mem_addr", mem_addr, em);
         chk(spad_addr === es, "R3", "spad_addr", spad_addr, es);
         ew = first && (gl > (1024 - int'(es >> 4)));
         chk(overrun_warn === ew, "R7", "overrun_warn", overrun_warn, ew);
         r = ($urandom % 4) != 0;
         beat_ready = r;
         start = poke && (beats == 2);
         if (start) begin qwc_in = 0; madr_in = $urandom; dir_to_mem = 1; stall_sel = 1; end
         @(negedge clk);
         start = 0;
         if (r) begin
            beats++; rem--; gl--; first = 0;
            em = em + 32'd16; es = es + 14'd16;
            if (gl == 0) begin
               em = em + AW'(s * 16);  // R1 group boundary, R2 skip
               if (rem > 0) begin gl = grp_of(t, rem); first = 1; end
            end
         end
      end
      beat_ready = $urandom;
      if (q == 0) chk(beat_valid === 1'b0, "R9", "no beat on zero count", beat_valid, 0);
      chk(done === 1'b1, q == 0 ? "R9" : "R5", "done pulse", done, 1);
      chk(busy === 1'b0 && qwc_left === '0, "R5", "idle and qwc_left zero", qwc_left, 0);
      if (d && st) exp_stall = em;
      chk(stall_wr === (d && st), "R6", "stall_wr", stall_wr, d && st);
      chk(stall_addr === exp_stall, "R6", "stall_addr", stall_addr, exp_stall);
      @(negedge clk);
      chk(done === 1'b0, "R5", "done single cycle", done, 0);
      chk(beat_valid === 1'b0, "R4", "valid low when idle", beat_valid, 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(busy === 0 && beat_valid === 0 && done === 0 && stall_wr === 0, "R10", "reset outputs", busy, 0);
      chk(qwc_left === '0 && stall_addr === '0, "R10", "reset regs", stall_addr, 0);
      rst_n = 1;
      @(negedge clk);
      // R1: zero group size means one group of the whole count
      run_xfer(6, 0, 3, 32'h1000, 14'h0100, 1, 1, 0);
      // R1: group size larger than the count
      run_xfer(5, 9, 2, 32'h2000, 14'h0000, 0, 0, 0);
      // R3 R7: group runs over scratchpad end and wraps
      run_xfer(8, 4, 1, 32'h3000, 14'h3FD0, 1, 1, 0);
      // R2: main-memory address wrap
      run_xfer(5, 2, 1, 32'hFFFF_FFD0, 14'h0040, 1, 1, 0);
      // R9: zero count, with and without stall record
      run_xfer(0, 3, 2, 32'h0000_ABC0, 14'h0010, 1, 1, 0);
      run_xfer(0, 3, 2, 32'h0000_DEF0, 14'h0010, 0, 1, 0);
      // R8: start while busy is ignored
      run_xfer(12, 3, 2, 32'h4000, 14'h1000, 0, 0, 1);
      run_xfer(1, 1, 7, 32'h5000, 14'h3FF0, 1, 1, 0);
      for (int i = 0; i < 40; i++) begin
         run_xfer($urandom_range(0, 40), $urandom_range(0, 9), $urandom_range(0, 5),
                  {$urandom, 4'h0}, SAW'({$urandom, 4'h0}),
                  $urandom, $urandom, $urandom_range(0, 3) == 0);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule